// File: doc/BRIEF.md
# Receive Status Queue with Request-to-Send Control

This block sits behind the deserializer of an asynchronous serial receiver. Every character the deserializer delivers is queued together with its own error flags: bad parity, a bad stop bit, a line break, and a lost-data marker. The reader sees the oldest entry at the head and removes it with a pop. The flags stay attached to the byte they describe, so software or a DMA engine can tell exactly which character was damaged.

A framing error on a character whose data bits are all zero is taken as a break. A break occupies two queue slots, and both slots hold 0x00. When the queue has no room for a character, that character is dropped. The lost-data flag is then set on the entry stored most recently.

The block also drives the active-low request-to-send pin (`rts_n`). When flow control is on, the pin is raised to ask the far end to pause once the fill level reaches a programmable threshold. It drops again when the level falls back below that threshold. A software bit can force the pin high at any time.

Top module: `rx_status_fifo`

## Requirements
- R1: After reset the fill count is 0, `head_valid` is 0 and `rts_n` is 0.
- R2: Each accepted character is stored with its parity and frame flags. Entries leave in arrival order, and the head always shows the oldest entry.
- R3: A character with the frame flag set and data 0x00 is a break. It writes two entries, each holding data 0x00 with the frame and break flags set, so the count grows by 2. A data byte of 0x00 without the frame flag is stored as one ordinary entry.
- R4: A frame error on non-zero data stores a single entry with the frame flag set and the break flag clear.
- R5: With 16 entries stored and no pop, an arriving character is discarded and the count stays at 16. The overrun flag is set on the newest stored entry, and all older entries keep their overrun flag clear.
- R6: A break that arrives with one free slot stores one 0x00 break entry, and that entry carries the overrun flag.
- R7: A pop while the queue is empty is ignored: the count stays 0, and the next pushed byte appears at the head.
- R8: A push and a pop in the same cycle leave the count unchanged, even when the queue is full. In that case the pushed byte is kept.
- R9: With flow control enabled, `rts_n` goes high one cycle after the count reaches the trigger level. It goes low one cycle after the count drops below that level.
- R10: A trigger level field of 0 means a threshold of 16.
- R11: With the force bit set, `rts_n` is high one cycle later, whatever the fill level.
- R12: With flow control disabled and the force bit clear, `rts_n` is low one cycle later, whatever the fill level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_data | input | 8 | Received data byte |
| rx_parity_err | input | 1 | The character failed its parity check |
| rx_frame_err | input | 1 | The first stop bit of the character sampled as 0 |
| pop | input | 1 | Remove the head entry |
| rts_flow_en | input | 1 | Enable automatic request-to-send control |
| rts_level | input | 4 | Trigger threshold; 0 means 16 |
| rts_force | input | 1 | Force `rts_n` high |
| head_valid | output | 1 | The queue is not empty |
| head_data | output | 8 | Data of the oldest entry (0 when empty) |
| head_overrun | output | 1 | Overrun flag of the head entry |
| head_parity | output | 1 | Parity flag of the head entry |
| head_frame | output | 1 | Frame flag of the head entry |
| head_break | output | 1 | Break flag of the head entry |
| fill_count | output | 5 | Number of stored entries, 0 to 16 |
| rts_n | output | 1 | Request-to-send pin; high asks the far end to pause |

## Verification
Characters are sent in several forms: clean, with a parity error, framed badly with non-zero data, and as a break (zero data with a frame error). Zero data without a frame error is also sent, to separate a real break from an ordinary null byte. Overflow is driven with a single character and with a break that meets exactly one free slot. These cases show whether the overrun mark lands on the newest entry or on an older one. The pin is stepped across the trigger at a middle level and at the level-0 encoding. Force and disable are applied at fill levels where the automatic rule would give the opposite answer.

// File: rtl/rxq_pkg.sv
// Package rxq_pkg: the type shared by the receive status queue modules.
// Assumes: characters are 8 bits wide.
package rxq_pkg;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic              ovr;   // a later character was lost after this one
        logic              brk;   // the entry is part of a break
        logic              frm;   // the stop bit was bad
        logic              par;   // the parity check failed
        logic [BYTE_W-1:0] data;  // received byte
    } rxq_entry_t;
endpackage

// File: rtl/rxq_admit.sv
// Module rxq_admit: decides how many queue slots an incoming character
// takes (2 for a break, 1 otherwise) and how many of them fit. It builds
// the entries to write and says where the overrun mark goes.
// Assumes: free_slots counts the slot released by a pop in the same cycle.
module rxq_admit
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_parity_err,
    input  logic              rx_frame_err,
    input  logic [CNT_W-1:0]  free_slots,
    output logic [1:0]        wr_cnt,
    output rxq_entry_t        wr_e0,
    output rxq_entry_t        wr_e1,
    output logic              mark_tail
);
    logic       is_brk;
    logic [1:0] n_req;
    logic       lost;

    // Classify the character and work out how many slots it asks for.
    always_comb begin
        is_brk = rx_frame_err && (rx_data == '0);
        n_req  = !rx_valid ? 2'd0 : (is_brk ? 2'd2 : 2'd1);
    end

    // Limit the write count to the room that is free.
    always_comb begin
        if (CNT_W'(n_req) <= free_slots) begin
            wr_cnt = n_req;
        end else begin
            wr_cnt = free_slots[1:0];
        end
        lost = (wr_cnt != n_req);
    end

    // Build the entries. The overrun mark goes on the last entry that is written.
    always_comb begin
        wr_e0.data = rx_data;
        wr_e0.par  = rx_parity_err;
        wr_e0.frm  = rx_frame_err;
        wr_e0.brk  = is_brk;
        wr_e0.ovr  = lost && (wr_cnt == 2'd1);
        wr_e1      = wr_e0;
        wr_e1.ovr  = 1'b0;
        mark_tail  = lost && (wr_cnt == 2'd0);
    end
endmodule

// File: rtl/rxq_store.sv
// Module rxq_store: a circular buffer of status entries. It can write
// zero, one or two entries per cycle, pop one entry, and set the overrun
// flag on the existing tail entry.
// Assumes: DEPTH is a power of two. mark_tail is only raised when the
// queue is full and no pop is taking place.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       wr_cnt,
    input  rxq_entry_t       wr_e0,
    input  rxq_entry_t       wr_e1,
    input  logic             mark_tail,
    input  logic             pop_req,
    output rxq_entry_t       head,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] free_slots
);
    rxq_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_ptr_p1, wr_ptr_m1;
    logic             pop_eff;

    // Decode the pop and the neighbouring write addresses.
    always_comb begin
        pop_eff    = pop_req && (count != '0);
        wr_ptr_p1  = wr_ptr + PTR_W'(1);
        wr_ptr_m1  = wr_ptr - PTR_W'(1);
        free_slots = CNT_W'(DEPTH) - count + CNT_W'(pop_eff);
        head       = mem[rd_ptr];
    end

    // Write the storage array.
    always_ff @(posedge clk) begin
        if (wr_cnt != 2'd0) mem[wr_ptr] <= wr_e0;
        if (wr_cnt == 2'd2) mem[wr_ptr_p1] <= wr_e1;
        if (mark_tail) mem[wr_ptr_m1].ovr <= 1'b1;
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + PTR_W'(wr_cnt);
            rd_ptr <= rd_ptr + PTR_W'(pop_eff);
            count  <= count + CNT_W'(wr_cnt) - CNT_W'(pop_eff);
        end
    end
endmodule

// File: rtl/rxq_rts.sv
// Module rxq_rts: registers the request-to-send pin from the fill level,
// the threshold, the enable and the force bit.
// Assumes: a threshold field of 0 encodes DEPTH.
module rxq_rts #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int LVL_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic             flow_en,
    input  logic [LVL_W-1:0] level,
    input  logic             force_hi,
    output logic             rts_n
);
    logic [CNT_W-1:0] lvl_eff;

    // Expand the threshold field; 0 stands for a full queue.
    always_comb lvl_eff = (level == '0) ? CNT_W'(DEPTH) : CNT_W'(level);

    // Register the pin so that it does not glitch.
    always_ff @(posedge clk) begin
        if (!rst_n) rts_n <= 1'b0;
        else        rts_n <= force_hi || (flow_en && (count >= lvl_eff));
    end
endmodule

// File: rtl/rx_status_fifo.sv
// Module rx_status_fifo: a receive queue that stores each character with
// its error flags and drives the request-to-send pin from the fill level.
// Assumes: rx_valid pulses for one cycle per character. The head fields
// read as zero when the queue is empty.
module rx_status_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int LVL_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_parity_err,
    input  logic              rx_frame_err,
    input  logic              pop,
    input  logic              rts_flow_en,
    input  logic [LVL_W-1:0]  rts_level,
    input  logic              rts_force,
    output logic              head_valid,
    output logic [BYTE_W-1:0] head_data,
    output logic              head_overrun,
    output logic              head_parity,
    output logic              head_frame,
    output logic              head_break,
    output logic [CNT_W-1:0]  fill_count,
    output logic              rts_n
);
    logic [1:0]       wr_cnt;
    rxq_entry_t       wr_e0, wr_e1, head;
    logic             mark_tail;
    logic [CNT_W-1:0] free_slots;

    rxq_admit #(.DEPTH(DEPTH)) u_admit (
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_parity_err(rx_parity_err),
        .rx_frame_err(rx_frame_err), .free_slots(free_slots),
        .wr_cnt(wr_cnt), .wr_e0(wr_e0), .wr_e1(wr_e1), .mark_tail(mark_tail)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_cnt(wr_cnt), .wr_e0(wr_e0), .wr_e1(wr_e1),
        .mark_tail(mark_tail), .pop_req(pop), .head(head),
        .count(fill_count), .free_slots(free_slots)
    );

    rxq_rts #(.DEPTH(DEPTH)) u_rts (
        .clk(clk), .rst_n(rst_n), .count(fill_count), .flow_en(rts_flow_en),
        .level(rts_level), .force_hi(rts_force), .rts_n(rts_n)
    );

    // Show the head entry, or zeros when the queue is empty.
    always_comb begin
        head_valid   = (fill_count != '0);
        head_data    = head_valid ? head.data : '0;
        head_overrun = head_valid && head.ovr;
        head_parity  = head_valid && head.par;
        head_frame   = head_valid && head.frm;
        head_break   = head_valid && head.brk;
    end
endmodule

// File: rtl/rx_status_fifo_chk.sv
// Module rx_status_fifo_chk: assertions at the ports of rx_status_fifo,
// attached to it by the bind statement at the end of this file.
module rx_status_fifo_chk #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic [7:0]       rx_data,
    input logic             rx_frame_err,
    input logic             pop,
    input logic             rts_flow_en,
    input logic             rts_force,
    input logic [CNT_W-1:0] fill_count,
    input logic             rts_n
);
    logic brk_in;
    always_comb brk_in = rx_frame_err && (rx_data == 8'h00);

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CNT_W'(DEPTH));

    assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == CNT_W'(DEPTH) && rx_valid && !pop) |=> fill_count == CNT_W'(DEPTH));

    assert_break_two_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && brk_in && !pop && fill_count <= CNT_W'(DEPTH - 2))
        |=> fill_count == $past(fill_count) + CNT_W'(2));

    assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !rx_valid && fill_count == '0) |=> fill_count == '0);

    assert_push_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !brk_in && pop && fill_count != '0) |=> $stable(fill_count));

    assert_force_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rts_force |=> rts_n);

    assert_disabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!rts_flow_en && !rts_force) |=> !rts_n);
endmodule

bind rx_status_fifo rx_status_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_frame_err(rx_frame_err), .pop(pop), .rts_flow_en(rts_flow_en),
    .rts_force(rts_force), .fill_count(fill_count), .rts_n(rts_n)
);

// File: tb/rx_status_fifo_tb.sv
module rx_status_fifo_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0, rx_parity_err = 1'b0, rx_frame_err = 1'b0;
    logic [7:0] rx_data = '0;
    logic       pop = 1'b0, rts_flow_en = 1'b0, rts_force = 1'b0;
    logic [3:0] rts_level = '0;
    logic       head_valid, head_overrun, head_parity, head_frame, head_break, rts_n;
    logic [7:0] head_data;
    logic [4:0] fill_count;
    int         checks = 0, failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rx_status_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err), .pop(pop),
        .rts_flow_en(rts_flow_en), .rts_level(rts_level), .rts_force(rts_force),
        .head_valid(head_valid), .head_data(head_data), .head_overrun(head_overrun),
        .head_parity(head_parity), .head_frame(head_frame), .head_break(head_break),
        .fill_count(fill_count), .rts_n(rts_n)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Push one character (and optionally pop in the same cycle); ends after the next negedge.
    task automatic push(input logic [7:0] d, input logic par, input logic frm, input logic with_pop = 1'b0);
        rx_valid = 1'b1; rx_data = d; rx_parity_err = par; rx_frame_err = frm; pop = with_pop;
        @(negedge clk);
        rx_valid = 1'b0; rx_data = '0; rx_parity_err = 1'b0; rx_frame_err = 1'b0; pop = 1'b0;
    endtask

    // Check the head entry, then pop it.
    task automatic pop_expect(input string req, input int d, input bit ovr, input bit par,
                              input bit frm, input bit brk);
        check(req, "head_valid", int'(head_valid), 1);
        check(req, "head_data", int'(head_data), d);
        check(req, "head_overrun", int'(head_overrun), int'(ovr));
        check(req, "head_parity", int'(head_parity), int'(par));
        check(req, "head_frame", int'(head_frame), int'(frm));
        check(req, "head_break", int'(head_break), int'(brk));
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic drain();
        while (fill_count != 0) begin
            pop = 1'b1;
            @(negedge clk);
        end
        pop = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "fill_count", int'(fill_count), 0);
        check("R1", "head_valid", int'(head_valid), 0);
        check("R1", "rts_n", int'(rts_n), 0);
    endtask

    task automatic t_order();
        push(8'h11, 1'b1, 1'b0);
        push(8'h22, 1'b0, 1'b0);
        push(8'h5A, 1'b0, 1'b1);
        check("R2", "count after 3", int'(fill_count), 3);
        pop_expect("R2", 'h11, 0, 1, 0, 0);
        pop_expect("R2", 'h22, 0, 0, 0, 0);
        pop_expect("R4", 'h5A, 0, 0, 1, 0);
        check("R2", "count drained", int'(fill_count), 0);
    endtask

    task automatic t_break();
        push(8'h00, 1'b0, 1'b1);
        check("R3", "count after break", int'(fill_count), 2);
        push(8'h00, 1'b0, 1'b0);
        check("R3", "count after null byte", int'(fill_count), 3);
        pop_expect("R3", 0, 0, 0, 1, 1);
        pop_expect("R3", 0, 0, 0, 1, 1);
        pop_expect("R3", 0, 0, 0, 0, 0);
    endtask

    task automatic t_empty_pop();
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        check("R7", "count after empty pop", int'(fill_count), 0);
        push(8'h33, 1'b0, 1'b0);
        check("R7", "count after push", int'(fill_count), 1);
        pop_expect("R7", 'h33, 0, 0, 0, 0);
    endtask

    task automatic t_pushpop();
        push(8'h44, 1'b0, 1'b0);
        push(8'h55, 1'b0, 1'b0, 1'b1);
        check("R8", "count with push+pop", int'(fill_count), 1);
        pop_expect("R8", 'h55, 0, 0, 0, 0);
    endtask

    task automatic t_overrun();
        for (int i = 0; i < DEPTH; i++) push(8'(i), 1'b0, 1'b0);
        check("R5", "count full", int'(fill_count), DEPTH);
        push(8'hAA, 1'b0, 1'b0);
        check("R5", "count after drop", int'(fill_count), DEPTH);
        for (int i = 0; i < DEPTH - 1; i++) pop_expect("R5", i, 0, 0, 0, 0);
        pop_expect("R5", DEPTH - 1, 1, 0, 0, 0);
        // A push and a pop together while full: the byte is kept.
        for (int i = 0; i < DEPTH; i++) push(8'(i + 32), 1'b0, 1'b0);
        push(8'hBB, 1'b0, 1'b0, 1'b1);
        check("R8", "count full push+pop", int'(fill_count), DEPTH);
        for (int i = 1; i < DEPTH; i++) pop_expect("R8", i + 32, 0, 0, 0, 0);
        pop_expect("R8", 'hBB, 0, 0, 0, 0);
    endtask

    task automatic t_break_onefree();
        for (int i = 0; i < DEPTH - 1; i++) push(8'(i + 64), 1'b0, 1'b0);
        push(8'h00, 1'b0, 1'b1);
        check("R6", "count", int'(fill_count), DEPTH);
        for (int i = 0; i < DEPTH - 1; i++) pop_expect("R6", i + 64, 0, 0, 0, 0);
        pop_expect("R6", 0, 1, 0, 1, 1);
    endtask

    task automatic t_rts();
        rts_flow_en = 1'b1; rts_level = 4'd4;
        for (int i = 0; i < 3; i++) push(8'(i), 1'b0, 1'b0);
        @(negedge clk);
        check("R9", "rts below level", int'(rts_n), 0);
        push(8'h03, 1'b0, 1'b0);
        check("R9", "rts same cycle as count", int'(rts_n), 0);
        @(negedge clk);
        check("R9", "rts at level", int'(rts_n), 1);
        pop = 1'b1; @(negedge clk); pop = 1'b0;
        @(negedge clk);
        check("R9", "rts after drop", int'(rts_n), 0);
        drain();
    endtask

    task automatic t_rts_level0();
        rts_flow_en = 1'b1; rts_level = 4'd0;
        for (int i = 0; i < DEPTH - 1; i++) push(8'(i), 1'b0, 1'b0);
        @(negedge clk);
        check("R10", "rts at 15", int'(rts_n), 0);
        push(8'h0F, 1'b0, 1'b0);
        @(negedge clk);
        check("R10", "rts at 16", int'(rts_n), 1);
        drain();
    endtask

    task automatic t_force_disable();
        rts_flow_en = 1'b0; rts_force = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R11", "forced while empty", int'(rts_n), 1);
        rts_force = 1'b0; rts_level = 4'd1;
        for (int i = 0; i < 5; i++) push(8'(i), 1'b0, 1'b0);
        @(negedge clk);
        check("R12", "disabled above level", int'(rts_n), 0);
        drain();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_break();
        t_empty_pop();
        t_pushpop();
        t_overrun();
        t_break_onefree();
        t_rts();
        t_rts_level0();
        t_force_disable();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule